// File: doc/BRIEF.md
# Pin-Configured Channel Status and Aux Bit Source

This block supplies the channel status (C), user (U) and validity (V) bit for every subframe of a two-channel digital audio transmitter that runs without a microcontroller. It watches the left/right frame clock and treats each level change as one subframe. At each change it samples the serial U and V pins and emits one C/U/V triple with a one-cycle valid strobe, which the line encoder latches. A high frame clock level marks the first subframe of a frame and a low level marks the second.

Two modes are available. In configuration mode (`mode_serial` low), the C bit comes from a 192-bit channel status block built from four static pins: copy, origin, emphasis and non-audio. The copy/origin pair also selects the consumer or the professional layout. In serial mode (`mode_serial` high), the C bit is sampled from the `copy_c` pin in the same way as U and V. A frame counter selects the channel status bit, so both subframes of a frame carry the same bit. The block-start line can work in two directions. When `blk_drive` is high, the block drives the line high through the first frame of each 192-frame block. When it is low, the block follows an external start pulse.

Top module: `pin_cs_formatter`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `cuv_valid` and `blk_out` are 0. The first frame after reset uses channel status index 0.
- R2: `cuv_valid` goes high for exactly one cycle, on the cycle after the first clock edge that sees `frame_clk` at a new level. It stays low when `frame_clk` has not changed.
- R3: In both modes, `u_out` and `v_out` equal `u_in` and `v_in` as sampled on the clock edge that detected the frame clock change.
- R4: When `mode_serial` is 1, `c_out` equals `copy_c` as sampled on the same edge. The block index and the configuration pins have no effect.
- R5: In configuration mode, the pair (`copy_c`, `orig`) sets three bits. (0,0) gives bit0=0, bit2=0, bit15=0. (0,1) gives bit0=0, bit2=0, bit15=1. (1,0) gives bit0=0, bit2=1, bit15=0. (1,1) selects the professional layout, with bit0=1.
- R6: In the consumer layout, bits 8 to 14 carry the category pattern 0,1,0,1,1,0,0, listed from bit 8 upward. Bit 1 is `nonaudio`. Bit 3 is `emph`. Bits 4 to 7 and bits 16 to 191 are 0.
- R7: In the professional layout, bit1 is `nonaudio`. Bits 2, 3 and 4 are 1,1,1 when `emph` is high and 1,0,0 when it is low. All other bits except bit0 are 0.
- R8: Both subframes of a frame carry the channel status bit of the same index. The index advances by one after the second subframe and wraps from 191 to 0.
- R9: When `blk_drive` is 1, `blk_oe` is 1. `blk_out` is 1 during both strobes of frame index 0 and 0 for every other frame.
- R10: When `blk_drive` is 0, `blk_oe` and `blk_out` are 0. If `blk_in` is high at a first-subframe edge, that frame uses index 0 and counting continues from there. `blk_in` has no effect at a second-subframe edge.
- R11: `sub_second` is 0 for a strobe caused by a rise of `frame_clk` and 1 for one caused by a fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk | input | 1 | Left/right frame clock, synchronous to clk |
| mode_serial | input | 1 | 0: C from configuration pins, 1: C serial on copy_c |
| copy_c | input | 1 | Copy configuration pin, or serial C data |
| orig | input | 1 | Origin configuration pin |
| emph | input | 1 | Emphasis configuration pin |
| nonaudio | input | 1 | High flags non-audio content |
| u_in | input | 1 | Serial user bit |
| v_in | input | 1 | Serial validity bit |
| blk_drive | input | 1 | 1: drive block start, 0: follow blk_in |
| blk_in | input | 1 | External block start |
| cuv_valid | output | 1 | One-cycle strobe per subframe |
| c_out | output | 1 | Channel status bit |
| u_out | output | 1 | User bit |
| v_out | output | 1 | Validity bit |
| sub_second | output | 1 | 0 first subframe, 1 second subframe |
| blk_out | output | 1 | Driven block start |
| blk_oe | output | 1 | Enable for blk_out |

## Verification
The channel status stream is compared over full 192-frame blocks for each of the four copy/origin combinations, with emphasis and non-audio set both ways. This separates the consumer bit positions from the professional ones and exposes any misplaced category or emphasis bit. A serial-mode pass uses a C pattern that is unrelated to the block index, which shows whether C is truly taken from the pin. Directed runs force a block start at the middle of a block, send a start pulse on a second subframe that must be ignored, hold the frame clock still, and apply a reset in the middle of a stream.

// File: rtl/cs_fmt_pkg.sv
package cs_fmt_pkg;

    // Category pattern, element 0 goes to status bit 8
    localparam logic [6:0] CAT_PATTERN = 7'b0011010;
    localparam int unsigned CAT_LSB    = 8;
    localparam int unsigned LINE_BIT   = 15;

    typedef struct packed {
        logic copy_c;
        logic orig;
        logic emph;
        logic nonaudio;
    } cs_cfg_t;

    typedef struct packed {
        logic c;
        logic u;
        logic v;
    } cuv_t;

    function automatic logic pro_layout(input cs_cfg_t cfg);
        return cfg.copy_c & cfg.orig;
    endfunction

    function automatic logic consumer_bit(input int unsigned idx, input cs_cfg_t cfg);
        logic b;
        b = 1'b0;
        if (idx == 1) b = cfg.nonaudio;
        else if (idx == 2) b = cfg.copy_c;
        else if (idx == 3) b = cfg.emph;
        else if (idx >= CAT_LSB && idx < CAT_LSB + 7) b = CAT_PATTERN[idx - CAT_LSB];
        else if (idx == LINE_BIT) b = cfg.orig;
        return b;
    endfunction

    function automatic logic professional_bit(input int unsigned idx, input cs_cfg_t cfg);
        logic b;
        b = 1'b0;
        case (idx)
            0: b = 1'b1;
            1: b = cfg.nonaudio;
            2: b = 1'b1;
            3, 4: b = cfg.emph;
            default: b = 1'b0;
        endcase
        return b;
    endfunction

    function automatic logic status_bit(input int unsigned idx, input cs_cfg_t cfg);
        return pro_layout(cfg) ? professional_bit(idx, cfg) : consumer_bit(idx, cfg);
    endfunction

endpackage

// File: rtl/cs_lrck_edge.sv
module cs_lrck_edge (
    input  logic clk,
    input  logic rst,
    input  logic frame_clk,
    output logic edge_stb,
    output logic first_sub
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= frame_clk;
        else     lvl_q <= frame_clk;
    end

    assign edge_stb  = frame_clk ^ lvl_q;
    assign first_sub = frame_clk;
endmodule

// File: rtl/cs_frame_track.sv
module cs_frame_track #(
    parameter int unsigned FRAMES = 192,
    localparam int unsigned IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_stb,
    input  logic             first_sub,
    input  logic             follow,
    input  logic             blk_in,
    output logic [IDX_W-1:0] idx,
    output logic             blk_flag
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);

    logic [IDX_W-1:0] next_q;
    logic [IDX_W-1:0] cur_q;
    logic [IDX_W-1:0] start_idx;

    assign start_idx = (follow && blk_in) ? '0 : next_q;
    assign idx       = first_sub ? start_idx : cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            next_q   <= '0;
            cur_q    <= '0;
            blk_flag <= 1'b0;
        end else if (edge_stb && first_sub) begin
            cur_q    <= start_idx;
            next_q   <= (start_idx == LAST) ? '0 : start_idx + 1'b1;
            blk_flag <= (start_idx == '0);
        end
    end
endmodule

// File: rtl/pin_cs_formatter.sv
module pin_cs_formatter #(
    parameter int unsigned FRAMES = 192
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_clk,
    input  logic mode_serial,
    input  logic copy_c,
    input  logic orig,
    input  logic emph,
    input  logic nonaudio,
    input  logic u_in,
    input  logic v_in,
    input  logic blk_drive,
    input  logic blk_in,
    output logic cuv_valid,
    output logic c_out,
    output logic u_out,
    output logic v_out,
    output logic sub_second,
    output logic blk_out,
    output logic blk_oe
);
    import cs_fmt_pkg::*;

    localparam int unsigned IDX_W = $clog2(FRAMES);

    logic             edge_stb;
    logic             first_sub;
    logic [IDX_W-1:0] idx;
    logic             blk_flag;
    cs_cfg_t          cfg;
    cuv_t             nxt;
    cuv_t             out_q;
    logic             valid_q;
    logic             second_q;

    cs_lrck_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .frame_clk (frame_clk),
        .edge_stb  (edge_stb),
        .first_sub (first_sub)
    );

    cs_frame_track #(.FRAMES(FRAMES)) u_track (
        .clk       (clk),
        .rst       (rst),
        .edge_stb  (edge_stb),
        .first_sub (first_sub),
        .follow    (!blk_drive),
        .blk_in    (blk_in),
        .idx       (idx),
        .blk_flag  (blk_flag)
    );

    assign cfg = '{copy_c: copy_c, orig: orig, emph: emph, nonaudio: nonaudio};

    always_comb begin
        nxt.c = mode_serial ? copy_c : status_bit(int'(idx), cfg);
        nxt.u = u_in;
        nxt.v = v_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            out_q    <= '0;
            second_q <= 1'b0;
        end else begin
            valid_q <= edge_stb;
            if (edge_stb) begin
                out_q    <= nxt;
                second_q <= !first_sub;
            end
        end
    end

    assign cuv_valid  = valid_q;
    assign c_out      = out_q.c;
    assign u_out      = out_q.u;
    assign v_out      = out_q.v;
    assign sub_second = second_q;
    assign blk_oe     = blk_drive;
    assign blk_out    = blk_drive & blk_flag;
endmodule

// File: rtl/cs_fmt_checker.sv
module cs_fmt_checker (
    input logic clk,
    input logic rst,
    input logic frame_clk,
    input logic mode_serial,
    input logic copy_c,
    input logic u_in,
    input logic v_in,
    input logic blk_drive,
    input logic cuv_valid,
    input logic c_out,
    input logic u_out,
    input logic v_out,
    input logic sub_second,
    input logic blk_out,
    input logic blk_oe
);
    logic seen_q;
    logic last_sub_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q     <= 1'b0;
            last_sub_q <= 1'b0;
        end else if (cuv_valid) begin
            seen_q     <= 1'b1;
            last_sub_q <= sub_second;
        end
    end

    a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
        cuv_valid |=> !cuv_valid);

    a_r2_needs_change: assert property (@(posedge clk) disable iff (rst)
        cuv_valid |-> $past(frame_clk) != $past(frame_clk, 2));

    a_r3_uv_sampled: assert property (@(posedge clk) disable iff (rst)
        cuv_valid |-> (u_out == $past(u_in)) && (v_out == $past(v_in)));

    a_r4_serial_c: assert property (@(posedge clk) disable iff (rst)
        (cuv_valid && $past(mode_serial)) |-> c_out == $past(copy_c));

    a_r10_follow_quiet: assert property (@(posedge clk) disable iff (rst)
        !blk_drive |-> (!blk_out && !blk_oe));

    a_r11_alternate: assert property (@(posedge clk) disable iff (rst)
        (cuv_valid && seen_q) |-> sub_second != last_sub_q);

    a_r11_level_match: assert property (@(posedge clk) disable iff (rst)
        cuv_valid |-> sub_second == !$past(frame_clk));
endmodule

bind pin_cs_formatter cs_fmt_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_clk  (frame_clk),
    .mode_serial(mode_serial),
    .copy_c     (copy_c),
    .u_in       (u_in),
    .v_in       (v_in),
    .blk_drive  (blk_drive),
    .cuv_valid  (cuv_valid),
    .c_out      (c_out),
    .u_out      (u_out),
    .v_out      (v_out),
    .sub_second (sub_second),
    .blk_out    (blk_out),
    .blk_oe     (blk_oe)
);

// File: tb/pin_cs_formatter_test.sv
module pin_cs_formatter_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_clk = 1'b0;
    logic mode_serial = 1'b0;
    logic copy_c = 1'b0;
    logic orig = 1'b0;
    logic emph = 1'b0;
    logic nonaudio = 1'b0;
    logic u_in = 1'b0;
    logic v_in = 1'b0;
    logic blk_drive = 1'b1;
    logic blk_in = 1'b0;
    logic cuv_valid, c_out, u_out, v_out, sub_second, blk_out, blk_oe;

    int checks = 0;
    int fails = 0;
    int bidx = 0;
    int k = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pin_cs_formatter uut (
        .clk(clk), .rst(rst), .frame_clk(frame_clk), .mode_serial(mode_serial),
        .copy_c(copy_c), .orig(orig), .emph(emph), .nonaudio(nonaudio),
        .u_in(u_in), .v_in(v_in), .blk_drive(blk_drive), .blk_in(blk_in),
        .cuv_valid(cuv_valid), .c_out(c_out), .u_out(u_out), .v_out(v_out),
        .sub_second(sub_second), .blk_out(blk_out), .blk_oe(blk_oe)
    );

    // {serial, copy, orig, emph, nonaudio}
    localparam logic [4:0] CFG_TAB [0:6] = '{
        5'b0_0000, 5'b0_0110, 5'b0_1001, 5'b0_1100,
        5'b0_1111, 5'b0_0011, 5'b1_0000
    };

    function automatic logic exp_c(int i, logic cp, logic og, logic em, logic na);
        if (cp && og) begin
            if (i == 0 || i == 2) return 1'b1;
            if (i == 1) return na;
            if (i == 3 || i == 4) return em;
            return 1'b0;
        end
        case (i)
            1: return na;
            2: return cp;
            3: return em;
            9, 11, 12: return 1'b1;
            15: return og;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b (frame %0d, t=%0t)", req, act, exp, bidx, $time);
        end
    endtask

    // one subframe; lvl 1 = first subframe
    task automatic do_sub(logic lvl, logic bin);
        logic eu, ev, ec, exp_blk;
        @(negedge clk);
        eu = k[0] ^ k[2];
        ev = k[1];
        frame_clk = lvl;
        u_in = eu;
        v_in = ev;
        blk_in = bin;
        if (mode_serial) copy_c = k[0] ^ k[3] ^ k[4];
        if (lvl && !blk_drive && bin) bidx = 0;
        ec = mode_serial ? copy_c : exp_c(bidx, copy_c, orig, emph, nonaudio);
        exp_blk = blk_drive && (bidx == 0);
        @(posedge clk); #1;
        chk("R2", cuv_valid, 1'b1);
        chk(mode_serial ? "R4" : (copy_c && orig ? "R7" : "R6"), c_out, ec);
        chk("R3", u_out, eu);
        chk("R3", v_out, ev);
        chk("R11", sub_second, !lvl);
        chk("R9", blk_out, exp_blk);
        chk("R9", blk_oe, blk_drive);
        @(posedge clk); #1;
        chk("R2", cuv_valid, 1'b0);
        k++;
        if (!lvl) bidx = (bidx == 191) ? 0 : bidx + 1;
    endtask

    task automatic do_frame(logic bin_first, logic bin_second);
        do_sub(1'b1, bin_first);
        do_sub(1'b0, bin_second);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1", cuv_valid, 1'b0);
        chk("R1", blk_out, 1'b0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1", cuv_valid, 1'b0);
        chk("R1", blk_out, 1'b0);

        // R2: no strobe without frame clock change
        for (int i = 0; i < 10; i++) begin
            @(posedge clk); #1;
            chk("R2", cuv_valid, 1'b0);
        end

        // table walk: one full block per configuration (R5..R8 across wrap)
        for (int t = 0; t < 7; t++) begin
            @(negedge clk);
            {mode_serial, copy_c, orig, emph, nonaudio} = CFG_TAB[t];
            for (int f = 0; f < 192; f++) do_frame(1'b0, 1'b0);
        end
        // R5: consumer copy/origin combinations are in entries 0,1,2,5
        @(negedge clk);
        mode_serial = 1'b0; copy_c = 1'b1; orig = 1'b1; emph = 1'b1; nonaudio = 1'b0;

        // R10: follow mode, forced start mid block
        blk_drive = 1'b0;
        while (bidx != 100) do_frame(1'b0, 1'b0);
        do_frame(1'b1, 1'b0);           // forced to index 0
        do_frame(1'b0, 1'b1);           // second-subframe pulse ignored, index 1
        for (int f = 0; f < 4; f++) do_frame(1'b0, 1'b0);
        chk("R10", blk_out, 1'b0);
        chk("R10", blk_oe, 1'b0);

        // back to driving: block start seen at wrap (R9, R8)
        @(negedge clk); blk_drive = 1'b1;
        while (bidx != 190) do_frame(1'b0, 1'b0);
        for (int f = 0; f < 4; f++) do_frame(1'b0, 1'b0);

        // R1: reset mid stream restarts at index 0
        while (bidx != 40) do_frame(1'b0, 1'b0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R1", cuv_valid, 1'b0);
        chk("R1", blk_out, 1'b0);
        @(negedge clk); rst = 1'b0;
        bidx = 0;
        for (int f = 0; f < 6; f++) do_frame(1'b0, 1'b0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule